// File: doc/BRIEF.md
# Memory-Mapped Flash Read Engine

This block turns word reads on a simple request/ready bus into serial flash read transactions. A read request carries a byte address inside the flash window. The engine lowers chip select and shifts out a one-byte opcode on a single lane. It then sends the flash address, idles for a number of dummy clocks, and shifts in enough data bits to fill one bus word. It returns that word with a one-cycle ready pulse.

A 4-bit read-mode code selects the opcode and the lane width of the address and data phases: single, dual or quad. Dummy clocks come either from a per-mode default or from a short override code. A select bit picks a 16-bit or a 24-bit flash address. When address continuation is allowed, chip select stays low after a word completes. A request for the next sequential word then resumes the data clocks at once, and a request to any other address ends the burst and starts a full transaction.

Top module: `flash_rd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, all four data-line enables are low and ready is low.
- R2: The opcode is sent most significant bit first on data line 0, over 8 serial clocks. The opcodes are: mode 0x0 sends 0x03, modes 0x1 and 0xC send 0x0B, 0x2 sends 0x3B, 0x3 sends 0xBB, 0xA sends 0x6B and 0xB sends 0xEB. Any other mode code behaves as mode 0x0.
- R3: Address and data lane widths by mode: 0x2 uses 1 lane for the address and 2 for data; 0x3 uses 2 and 2; 0xA uses 1 and 4; 0xB uses 4 and 4; all other modes use 1 and 1. On each clock the highest-numbered active lane carries the most significant bit. Single-lane input data is taken from data line 1.
- R4: With the dummy override off, the dummy clock count is 0 for mode 0x0 and unknown modes, 8 for modes 0x1, 0xC, 0x2 and 0xA, 4 for mode 0x3 and 6 for mode 0xB.
- R5: With the dummy override on, code 0x1 gives 4 dummy clocks, 0x3 gives 2 and 0x7 gives 1. Any other code keeps the mode default.
- R6: With the short-address select at 0, the 24 low address bits are sent. At 1, only the 16 low address bits are sent.
- R7: The first byte received lands in bits 7:0 of the returned word, the next in 15:8, and so on. Ready is high for exactly one cycle, with the word valid in that cycle.
- R8: The line enables are 0001 during the opcode phase. During the address phase they cover the address lanes (0001, 0011 or 1111). During the dummy and data phases they are 0000.
- R9: With continuation allowed, chip select stays low after a word completes. A request for the address 4 above the previous one adds only data clocks, with no chip-select toggle and no opcode or address. Any other address raises chip select and runs a full transaction.
- R10: With continuation disabled, chip select rises after every word, and every request runs a full transaction.
- R11: The serial clock runs at half the system clock rate and is low while chip select is high. Line values and enables change only while the serial clock is low. A full transaction has 8 + address clocks + dummy clocks + data clocks rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request; held with the address until ready |
| req_addr | input | AW | Byte address in the flash window |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8*WB | Returned word, little-endian |
| cfg_read_mode | input | 4 | Read-mode code (opcode and lane widths) |
| cfg_dummy_en | input | 1 | Dummy override enable |
| cfg_dummy_code | input | 4 | Dummy override code |
| cfg_addr_short | input | 1 | 1 selects a 16-bit flash address |
| cfg_cont_dis | input | 1 | 1 disables address continuation |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_io_out | output | 4 | Data line output values |
| spi_io_oe | output | 4 | Data line output enables |
| spi_io_in | input | 4 | Data line input values |

## Verification
A sequencer stuck in the wrong phase or using a wrong phase count shows first in the number of serial clock edges within one chip-select window. That count is compared at the ready pulse of every full transaction. A wrong opcode, lane width or address length is visible on the data lines within the first 8 to 32 serial clocks, because the flash model captures those bits. A dummy count that is off by even one clock, or a wrong byte order, corrupts the returned word of that same read. A broken continuation decision shows as an extra or a missing chip-select edge before the next ready pulse.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    // Lane counts are coded as their numeric value: 1, 2 or 4.
    typedef struct packed {
        logic [7:0] opcode;
        logic [2:0] alanes;
        logic [2:0] dlanes;
        logic [3:0] dummy;
        logic       addr2;
        logic       cont;
    } rd_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_DONE,
        ST_HOLD,
        ST_GAP
    } fsm_t;

    function automatic logic [3:0] lane_mask(input logic [2:0] lanes);
        case (lanes)
            3'd2:    return 4'b0011;
            3'd4:    return 4'b1111;
            default: return 4'b0001;
        endcase
    endfunction

    // log2 of a lane count: 1->0, 2->1, 4->2
    function automatic logic [1:0] lane_shift(input logic [2:0] lanes);
        return {lanes[2], lanes[1]};
    endfunction

endpackage

// File: rtl/frd_mode_decode.sv
module frd_mode_decode
    import flash_rd_pkg::*;
#(
    parameter int DUMMY_FAST = 8,
    parameter int DUMMY_DIO  = 4,
    parameter int DUMMY_QIO  = 6
) (
    input  logic [3:0] mode,
    input  logic       dummy_en,
    input  logic [3:0] dummy_code,
    input  logic       addr_short,
    input  logic       cont_dis,
    output rd_cfg_t    cfg
);

    logic [3:0] dflt;

    always_comb begin
        cfg        = '0;
        cfg.opcode = 8'h03;
        cfg.alanes = 3'd1;
        cfg.dlanes = 3'd1;
        dflt       = 4'd0;
        case (mode)
            4'h1, 4'hC: begin
                cfg.opcode = 8'h0B;
                dflt       = 4'(DUMMY_FAST);
            end
            4'h2: begin
                cfg.opcode = 8'h3B;
                cfg.dlanes = 3'd2;
                dflt       = 4'(DUMMY_FAST);
            end
            4'h3: begin
                cfg.opcode = 8'hBB;
                cfg.alanes = 3'd2;
                cfg.dlanes = 3'd2;
                dflt       = 4'(DUMMY_DIO);
            end
            4'hA: begin
                cfg.opcode = 8'h6B;
                cfg.dlanes = 3'd4;
                dflt       = 4'(DUMMY_FAST);
            end
            4'hB: begin
                cfg.opcode = 8'hEB;
                cfg.alanes = 3'd4;
                cfg.dlanes = 3'd4;
                dflt       = 4'(DUMMY_QIO);
            end
            default: ;
        endcase
        cfg.dummy = dflt;
        if (dummy_en) begin
            case (dummy_code)
                4'h1:    cfg.dummy = 4'd4;
                4'h3:    cfg.dummy = 4'd2;
                4'h7:    cfg.dummy = 4'd1;
                default: cfg.dummy = dflt;
            endcase
        end
        cfg.addr2 = addr_short;
        cfg.cont  = !cont_dis;
    end

endmodule

// File: rtl/frd_byte_order.sv
module frd_byte_order #(
    parameter int WB = 4
) (
    input  logic [8*WB-1:0] stream,
    output logic [8*WB-1:0] word
);

    localparam int DW = 8 * WB;

    for (genvar g = 0; g < WB; g++) begin : g_byte
        assign word[8*g +: 8] = stream[DW-8*(g+1) +: 8];
    end

endmodule

// File: rtl/frd_seq.sv
module frd_seq
    import flash_rd_pkg::*;
#(
    parameter int AW = 24,
    parameter int WB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  rd_cfg_t       cfg_in,
    input  logic [3:0]    io_in,
    output logic          ready,
    output logic [8*WB-1:0] raw_word,
    output logic          sclk,
    output logic          cs_n,
    output logic [3:0]    io_out,
    output logic [3:0]    io_oe
);

    localparam int DW = 8 * WB;
    localparam int CW = $clog2((DW > 24) ? DW : 24) + 1;

    typedef struct packed {
        fsm_t          st;
        rd_cfg_t       cfg;
        logic [CW-1:0] cnt;
        logic [31:0]   sh_out;
        logic [DW-1:0] sh_in;
        logic [DW-1:0] word;
        logic [AW-1:0] nxt;
        logic          cs_n;
        logic          sclk;
        logic          rdy;
    } seq_t;

    seq_t q, d;

    logic [2:0]    lanes;
    logic [CW-1:0] a_bits;
    logic [CW-1:0] last;
    logic [3:0]    in_bits;
    logic [DW-1:0] sh_in_nx;
    logic [23:0]   faddr;

    always_comb begin
        case (q.st)
            ST_CMD:  lanes = 3'd1;
            ST_ADDR: lanes = q.cfg.alanes;
            default: lanes = q.cfg.dlanes;
        endcase
    end

    always_comb begin
        a_bits = q.cfg.addr2 ? CW'(16) : CW'(24);
        case (q.st)
            ST_CMD:   last = CW'(7);
            ST_ADDR:  last = (a_bits >> lane_shift(q.cfg.alanes)) - CW'(1);
            ST_DUMMY: last = CW'(q.cfg.dummy) - CW'(1);
            default:  last = (CW'(DW) >> lane_shift(q.cfg.dlanes)) - CW'(1);
        endcase
    end

    always_comb begin
        in_bits  = (q.cfg.dlanes == 3'd1) ? {3'b000, io_in[1]} : (io_in & lane_mask(q.cfg.dlanes));
        sh_in_nx = (q.sh_in << q.cfg.dlanes) | DW'(in_bits);
        faddr    = 24'(q.nxt);
    end

    always_comb begin
        d     = q;
        d.rdy = 1'b0;
        case (q.st)
            ST_IDLE: begin
                d.cs_n = 1'b1;
                d.sclk = 1'b0;
                if (req_valid) begin
                    d.st     = ST_CMD;
                    d.cfg    = cfg_in;
                    d.cs_n   = 1'b0;
                    d.cnt    = '0;
                    d.sh_out = {cfg_in.opcode, 24'h0};
                    d.nxt    = req_addr;
                end
            end
            ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA: begin
                if (!q.sclk) begin
                    d.sclk = 1'b1;
                end else begin
                    d.sclk   = 1'b0;
                    d.cnt    = q.cnt + CW'(1);
                    d.sh_out = q.sh_out << lanes;
                    if (q.st == ST_DATA) begin
                        d.sh_in = sh_in_nx;
                    end
                    if (q.cnt == last) begin
                        d.cnt = '0;
                        case (q.st)
                            ST_CMD: begin
                                d.st     = ST_ADDR;
                                d.sh_out = q.cfg.addr2 ? {faddr[15:0], 16'h0} : {faddr, 8'h0};
                            end
                            ST_ADDR: d.st = (q.cfg.dummy != 4'd0) ? ST_DUMMY : ST_DATA;
                            ST_DUMMY: d.st = ST_DATA;
                            default: begin
                                d.st   = ST_DONE;
                                d.rdy  = 1'b1;
                                d.word = sh_in_nx;
                                d.nxt  = q.nxt + AW'(WB);
                                d.cs_n = !q.cfg.cont;
                            end
                        endcase
                    end
                end
            end
            ST_DONE: begin
                d.st = q.cfg.cont ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD: begin
                if (req_valid) begin
                    if (req_addr == q.nxt) begin
                        d.st  = ST_DATA;
                        d.cnt = '0;
                    end else begin
                        d.st   = ST_GAP;
                        d.cs_n = 1'b1;
                    end
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (lanes)
            3'd2:    io_out = {2'b00, q.sh_out[31:30]};
            3'd4:    io_out = q.sh_out[31:28];
            default: io_out = {3'b000, q.sh_out[31]};
        endcase
        case (q.st)
            ST_CMD:  io_oe = 4'b0001;
            ST_ADDR: io_oe = lane_mask(q.cfg.alanes);
            default: io_oe = 4'b0000;
        endcase
    end

    assign ready    = q.rdy;
    assign raw_word = q.word;
    assign sclk     = q.sclk;
    assign cs_n     = q.cs_n;

    // R11: clock idles low outside a chip-select window
    p_idle_clock_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q.cs_n |-> !q.sclk);

    // R11: lines and enables do not move while the clock is high
    p_stable_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q.sclk |-> ($stable(io_out) && $stable(io_oe)));

    // R7: ready lasts one cycle
    p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.rdy |=> !q.rdy);

    // R2: a transaction only opens in answer to a request
    p_cs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.cs_n) |-> $past(req_valid));

    // R10: chip select is released with the word when continuation is off
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rdy && !q.cfg.cont) |-> q.cs_n);

    // R9: chip select is kept after the word when continuation is on
    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rdy && q.cfg.cont) |=> !q.cs_n);

endmodule

// File: rtl/flash_rd_engine.sv
module flash_rd_engine
    import flash_rd_pkg::*;
#(
    parameter int AW         = 24,
    parameter int WB         = 4,
    parameter int DUMMY_FAST = 8,
    parameter int DUMMY_DIO  = 4,
    parameter int DUMMY_QIO  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    output logic            req_ready,
    output logic [8*WB-1:0] req_rdata,
    input  logic [3:0]      cfg_read_mode,
    input  logic            cfg_dummy_en,
    input  logic [3:0]      cfg_dummy_code,
    input  logic            cfg_addr_short,
    input  logic            cfg_cont_dis,
    output logic            spi_sclk,
    output logic            spi_cs_n,
    output logic [3:0]      spi_io_out,
    output logic [3:0]      spi_io_oe,
    input  logic [3:0]      spi_io_in
);

    localparam int DW = 8 * WB;

    rd_cfg_t       cfg;
    logic [DW-1:0] raw_word;

    frd_mode_decode #(
        .DUMMY_FAST (DUMMY_FAST),
        .DUMMY_DIO  (DUMMY_DIO),
        .DUMMY_QIO  (DUMMY_QIO)
    ) u_decode (
        .mode       (cfg_read_mode),
        .dummy_en   (cfg_dummy_en),
        .dummy_code (cfg_dummy_code),
        .addr_short (cfg_addr_short),
        .cont_dis   (cfg_cont_dis),
        .cfg        (cfg)
    );

    frd_seq #(
        .AW (AW),
        .WB (WB)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .cfg_in    (cfg),
        .io_in     (spi_io_in),
        .ready     (req_ready),
        .raw_word  (raw_word),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .io_out    (spi_io_out),
        .io_oe     (spi_io_oe)
    );

    frd_byte_order #(
        .WB (WB)
    ) u_order (
        .stream (raw_word),
        .word   (req_rdata)
    );

endmodule

// File: tb/tb_flash_rd_engine.sv
module tb_flash_rd_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_ready;
    logic [31:0] req_rdata;
    logic [3:0]  cfg_read_mode = 4'h0;
    logic        cfg_dummy_en = 1'b0;
    logic [3:0]  cfg_dummy_code = 4'h0;
    logic        cfg_addr_short = 1'b0;
    logic        cfg_cont_dis = 1'b1;
    logic        spi_sclk;
    logic        spi_cs_n;
    logic [3:0]  spi_io_out;
    logic [3:0]  spi_io_oe;
    logic [3:0]  spi_io_in = 4'h0;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    flash_rd_engine dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_ready      (req_ready),
        .req_rdata      (req_rdata),
        .cfg_read_mode  (cfg_read_mode),
        .cfg_dummy_en   (cfg_dummy_en),
        .cfg_dummy_code (cfg_dummy_code),
        .cfg_addr_short (cfg_addr_short),
        .cfg_cont_dis   (cfg_cont_dis),
        .spi_sclk       (spi_sclk),
        .spi_cs_n       (spi_cs_n),
        .spi_io_out     (spi_io_out),
        .spi_io_oe      (spi_io_oe),
        .spi_io_in      (spi_io_in)
    );

    // expected behaviour, taken from the requirements
    function automatic logic [7:0] e_op(input logic [3:0] m);
        case (m)
            4'h1, 4'hC: return 8'h0B;
            4'h2:       return 8'h3B;
            4'h3:       return 8'hBB;
            4'hA:       return 8'h6B;
            4'hB:       return 8'hEB;
            default:    return 8'h03;
        endcase
    endfunction

    function automatic int e_al(input logic [3:0] m);
        if (m == 4'h3) return 2;
        if (m == 4'hB) return 4;
        return 1;
    endfunction

    function automatic int e_dl(input logic [3:0] m);
        if (m == 4'h2 || m == 4'h3) return 2;
        if (m == 4'hA || m == 4'hB) return 4;
        return 1;
    endfunction

    function automatic int e_dc(input logic [3:0] m, input logic en, input logic [3:0] code);
        int dflt;
        case (m)
            4'h1, 4'hC, 4'h2, 4'hA: dflt = 8;
            4'h3:                   dflt = 4;
            4'hB:                   dflt = 6;
            default:                dflt = 0;
        endcase
        if (en) begin
            if (code == 4'h1) return 4;
            if (code == 4'h3) return 2;
            if (code == 4'h7) return 1;
        end
        return dflt;
    endfunction

    function automatic logic [7:0] fb(input logic [23:0] a);
        return (a[7:0] * 8'd37) ^ a[15:8] ^ (a[23:16] + 8'h5A);
    endfunction

    function automatic logic [3:0] mk(input int l);
        if (l == 2) return 4'b0011;
        if (l == 4) return 4'b1111;
        return 4'b0001;
    endfunction

    // expectations for the current configuration
    logic [7:0] m_op = 8'h03;
    int m_al = 1, m_dl = 1, m_ac = 24, m_dc = 0;

    // flash model state
    int          edge_n = 0;
    int          csf = 0;
    int          oe_bad = 0;
    logic [7:0]  cap_op = '0;
    logic [23:0] cap_addr = '0;
    int s_al = 1, s_dl = 1, s_ac = 24, s_dc = 0;

    always @(negedge spi_cs_n) begin
        edge_n   = 0;
        csf      = csf + 1;
        cap_op   = '0;
        cap_addr = '0;
        oe_bad   = 0;
        s_al     = m_al;
        s_dl     = m_dl;
        s_ac     = m_ac;
        s_dc     = m_dc;
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            logic [3:0] eoe;
            if (edge_n < 8)              eoe = 4'b0001;
            else if (edge_n < 8 + s_ac)  eoe = mk(s_al);
            else                         eoe = 4'b0000;
            if (spi_io_oe != eoe) oe_bad = oe_bad + 1;
            if (edge_n < 8)
                cap_op = {cap_op[6:0], spi_io_out[0]};
            else if (edge_n < 8 + s_ac)
                cap_addr = (cap_addr << s_al) | 24'(spi_io_out & mk(s_al));
            edge_n = edge_n + 1;
        end
    end

    always @(negedge spi_sclk) begin
        int j, bp, c;
        logic [7:0] b;
        logic [7:0] v;
        #1;
        if (!spi_cs_n) begin
            j = edge_n - (8 + s_ac + s_dc);
            if (j >= 0) begin
                bp = j * s_dl;
                c  = bp % 8;
                b  = fb(cap_addr + 24'(bp / 8));
                v  = (b >> (8 - c - s_dl)) & 8'(mk(s_dl));
                if (s_dl == 1) spi_io_in = {2'b00, v[0], 1'b0};
                else           spi_io_in = v[3:0];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [3:0] m, input logic den, input logic [3:0] dcode,
                           input logic short, input logic cdis);
        @(negedge clk);
        cfg_read_mode  = m;
        cfg_dummy_en   = den;
        cfg_dummy_code = dcode;
        cfg_addr_short = short;
        cfg_cont_dis   = cdis;
        m_op = e_op(m);
        m_al = e_al(m);
        m_dl = e_dl(m);
        m_dc = e_dc(m, den, dcode);
        m_ac = (short ? 16 : 24) / m_al;
    endtask

    // one bus read; fresh=1 expects a full transaction, 0 a continued burst
    task automatic rd(input logic [23:0] a, input bit fresh, input string tag);
        int f0 = csf;
        int t = 0;
        logic [31:0] w, ew;
        logic [23:0] ea;
        ea = cfg_addr_short ? {8'h00, a[15:0]} : a;
        ew = {fb(ea + 24'd3), fb(ea + 24'd2), fb(ea + 24'd1), fb(ea)};
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        do begin
            @(negedge clk);
            t++;
        end while (!req_ready && t < 4000);
        w = req_rdata;
        req_valid = 1'b0;
        chk(t < 4000, "R7 ready timeout", 32'(t), 32'd4000);
        chk(w == ew, tag, w, ew);
        if (fresh) begin
            chk(csf == f0 + 1, "R10 one chip-select window", 32'(csf - f0), 32'd1);
            chk(cap_op == m_op, "R2 opcode", 32'(cap_op), 32'(m_op));
            chk(cap_addr == ea, "R6 address sent", 32'(cap_addr), 32'(ea));
            chk(edge_n == 8 + m_ac + m_dc + 32 / m_dl, "R11 R4 clock edge count",
                32'(edge_n), 32'(8 + m_ac + m_dc + 32 / m_dl));
            chk(oe_bad == 0, "R8 line enables", 32'(oe_bad), 32'd0);
        end else begin
            chk(csf == f0, "R9 no new chip-select window", 32'(csf - f0), 32'd0);
        end
    endtask

    task automatic t_reset();
        #1;
        chk(spi_cs_n === 1'b1, "R1 cs_n", 32'(spi_cs_n), 32'd1);
        chk(spi_sclk === 1'b0, "R1 sclk", 32'(spi_sclk), 32'd0);
        chk(spi_io_oe === 4'h0, "R1 io_oe", 32'(spi_io_oe), 32'd0);
        chk(req_ready === 1'b0, "R1 ready", 32'(req_ready), 32'd0);
    endtask

    task automatic t_modes();
        logic [3:0] ml[8] = '{4'h0, 4'h1, 4'hC, 4'h2, 4'h3, 4'hA, 4'hB, 4'h5};
        for (int i = 0; i < 8; i++) begin
            set_cfg(ml[i], 1'b0, 4'h0, 1'b0, 1'b1);
            rd(24'h10_0000 + 24'(i * 24'h1357), 1'b1, "R3 R7 word per mode");
        end
    endtask

    task automatic t_dummy();
        logic [3:0] cl[4] = '{4'h1, 4'h3, 4'h7, 4'h5};
        for (int i = 0; i < 4; i++) begin
            set_cfg(4'h1, 1'b1, cl[i], 1'b0, 1'b1);
            rd(24'h02_0040 + 24'(i * 8), 1'b1, "R5 override dummy word");
        end
        set_cfg(4'hB, 1'b1, 4'h3, 1'b0, 1'b1);
        rd(24'h33_0010, 1'b1, "R5 quad override dummy word");
        set_cfg(4'h3, 1'b0, 4'h7, 1'b0, 1'b1);
        rd(24'h44_0020, 1'b1, "R4 dual default dummy word");
    endtask

    task automatic t_short();
        set_cfg(4'h0, 1'b0, 4'h0, 1'b1, 1'b1);
        rd(24'hAB_1234, 1'b1, "R6 short address single");
        set_cfg(4'hB, 1'b0, 4'h0, 1'b1, 1'b1);
        rd(24'hCD_5678, 1'b1, "R6 short address quad");
    endtask

    task automatic t_cont();
        set_cfg(4'hA, 1'b0, 4'h0, 1'b0, 1'b0);
        rd(24'h00_0100, 1'b1, "R9 first word");
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b0, "R9 cs held", 32'(spi_cs_n), 32'd0);
        rd(24'h00_0104, 1'b0, "R9 continued word 1");
        rd(24'h00_0108, 1'b0, "R9 continued word 2");
        rd(24'h00_0200, 1'b1, "R9 non-sequential word");
        set_cfg(4'h3, 1'b0, 4'h0, 1'b0, 1'b0);
        rd(24'h01_0000, 1'b1, "R9 dual first word");
        rd(24'h01_0004, 1'b0, "R9 dual continued word");
    endtask

    task automatic t_nocont();
        set_cfg(4'h2, 1'b0, 4'h0, 1'b0, 1'b1);
        rd(24'h00_0300, 1'b1, "R10 first word");
        repeat (2) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R10 cs released", 32'(spi_cs_n), 32'd1);
        chk(spi_sclk == 1'b0, "R11 sclk idle", 32'(spi_sclk), 32'd0);
        rd(24'h00_0304, 1'b1, "R10 sequential word still full");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_modes();
        t_dummy();
        t_short();
        t_cont();
        t_nocont();
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule